// File: doc/BRIEF.md
# Two-Queue Credit-Based Traffic Shaper

This block decides, cycle by cycle, whether each of four transmit queues may start sending a frame. Two credit-based shaper instances exist. They follow the IEEE 802.1Qav style. Instance 0 can serve only queue 0 and instance 1 only queue 1. Queues 2 and 3 are never shaped and are always eligible.

A shaped queue keeps a credit value in a biased domain, where 0x8000_0000 stands for zero credit. While frames wait and the queue is not sending, the credit rises by a programmed rate code each cycle. While the queue sends, the credit falls by a fixed step. The credit saturates at a programmed upper limit and at a fixed lower floor. The queue is eligible when its credit is at or above zero.

Configuration arrives one word at a time through a write port. The write selects one of three per-queue words and a queue number. The block enforces an enable order on the two shapers: queue 0 must be shaped before queue 1 can be shaped. Any write that would break this order is dropped.

Top module: `credit_shaper`

## Requirements
- R1: After reset, no queue is shaped, every credit sits at zero (0x8000_0000) and all four eligibility outputs are high, whatever the transmit and pending inputs do.
- R2: A control-word write (cfg_reg = 0) carries the shaper select in bits 7:6. Code 2'b10 shapes queue 0 and code 2'b11 shapes queue 1. Code 2'b00 unshapes the addressed queue. Any other code for queue 0 or 1, and any control write to queue 2 or 3, changes nothing.
- R3: A rate-word write (cfg_reg = 1) to queue 0 or 1 sets the idle rate code from bits 15:0 and the keep-credit flag from bit 30.
- R4: A limit-word write (cfg_reg = 2) to queue 0 or 1 sets the 32-bit biased upper credit limit. Accrual never carries the credit above this limit.
- R5: A shaped queue is eligible exactly when its credit is at or above 0x8000_0000. An unshaped queue, and queues 2 and 3, are always eligible.
- R6: In each cycle that a shaped queue has a frame pending and is not transmitting, its credit rises by the idle rate code, clipped at the upper limit.
- R7: In each cycle that a shaped queue transmits, its credit falls by SEND_STEP (default 1000), clipped at the floor 0x8000_0000 − LO_CREDIT (default 3000). Transmit takes precedence over pending.
- R8: When a shaped queue is neither pending nor transmitting and its credit is above zero, the credit returns to zero in one cycle if keep-credit is clear. If keep-credit is set, the credit is held.
- R9: When a shaped queue is neither pending nor transmitting and its credit is below zero, the credit rises by the idle rate code each cycle. It stops exactly at zero.
- R10: Enabling queue 1 shaping while queue 0 is unshaped is ignored. Disabling queue 0 shaping while queue 1 is shaped is also ignored.
- R11: An unshaped queue's credit is forced to zero. A queue that is unshaped and later shaped again starts from zero credit. It is eligible at once, even if it held negative credit before it was unshaped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one shaper tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_reg | input | 2 | Word select: 0 control, 1 rate, 2 limit, 3 none |
| cfg_queue | input | 2 | Queue addressed by the write |
| cfg_wdata | input | 32 | Write data |
| q_pend | input | 4 | Per-queue frame-pending indication |
| q_xmit | input | 4 | Per-queue transmitting indication |
| q_elig | output | 4 | Per-queue transmit-eligible output |

## Verification
The bench targets several corner cases, each with a distinct failure signature.
- Limit clipping: a design that ignores the upper limit lets a long pending run bank too much credit, so the queue becomes eligible again too early after one frame.
- Keep-credit flag: if the flag is mishandled, the held positive credit is lost during an idle gap, so the queue becomes eligible later than the rate predicts.
- Negative recovery: a queue must stop at zero rather than overshoot.
- Floor: a queue that transmits for a long time must stop at the floor, otherwise its recovery time grows past the expected count.
- Ordering guard: a design with a broken guard either lets queue 1 shape before queue 0, or lets queue 0 drop out beneath queue 1. In both cases the eligibility after the next transmit cycle is wrong.

// File: rtl/shaper_pkg.sv
package shaper_pkg;

    localparam int CRED_W   = 32;
    localparam int SLOPE_W  = 16;
    localparam int SEL_LSB  = 6;
    localparam int KEEP_BIT = 30;

    // biased zero point of the credit domain
    localparam logic [CRED_W-1:0] CRED_ZERO = 32'h8000_0000;

    localparam logic [1:0] SEL_OFF = 2'b00;

    typedef enum logic [1:0] {
        REG_CTL   = 2'd0,
        REG_RATE  = 2'd1,
        REG_LIMIT = 2'd2,
        REG_NONE  = 2'd3
    } cfg_reg_e;

endpackage

// File: rtl/shaper_cfg.sv
module shaper_cfg
    import shaper_pkg::*;
#(
    parameter int NUM_Q       = 4,
    parameter int NUM_SHAPERS = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr,
    input  logic [1:0]                           reg_sel,
    input  logic [$clog2(NUM_Q)-1:0]             queue,
    input  logic [31:0]                          wdata,
    output logic [NUM_SHAPERS-1:0]               en,
    output logic [NUM_SHAPERS-1:0][SLOPE_W-1:0]  slope,
    output logic [NUM_SHAPERS-1:0]               keep,
    output logic [NUM_SHAPERS-1:0][CRED_W-1:0]   limit
);

    localparam int QW = $clog2(NUM_Q);

    typedef struct packed {
        logic [NUM_SHAPERS-1:0]              en;
        logic [NUM_SHAPERS-1:0][SLOPE_W-1:0] slope;
        logic [NUM_SHAPERS-1:0]              keep;
        logic [NUM_SHAPERS-1:0][CRED_W-1:0]  limit;
    } cfg_t;

    cfg_t st_d, st_q;

    logic [1:0]             sel_code;
    logic [NUM_SHAPERS-1:0] upper_on;   // next-lower-priority shaper active
    logic [NUM_SHAPERS-1:0] lower_on;   // next-higher-priority shaper active

    assign sel_code = wdata[SEL_LSB +: 2];
    assign upper_on = {1'b0, st_q.en[NUM_SHAPERS-1:1]};
    assign lower_on = {st_q.en[NUM_SHAPERS-2:0], 1'b1};

    always_comb begin
        st_d = st_q;
        if (wr) begin
            for (int i = 0; i < NUM_SHAPERS; i++) begin
                if (queue == QW'(i)) begin
                    case (cfg_reg_e'(reg_sel))
                        REG_CTL: begin
                            if (sel_code == SEL_OFF) begin
                                if (!upper_on[i]) st_d.en[i] = 1'b0;
                            end else if (sel_code == {1'b1, 1'(i)}) begin
                                if (lower_on[i]) st_d.en[i] = 1'b1;
                            end
                        end
                        REG_RATE: begin
                            st_d.slope[i] = wdata[SLOPE_W-1:0];
                            st_d.keep[i]  = wdata[KEEP_BIT];
                        end
                        REG_LIMIT: st_d.limit[i] = wdata;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en    = st_q.en;
    assign slope = st_q.slope;
    assign keep  = st_q.keep;
    assign limit = st_q.limit;

endmodule

// File: rtl/shaper_credit.sv
module shaper_credit
    import shaper_pkg::*;
#(
    parameter int unsigned SEND_STEP = 1000,
    parameter int unsigned LO_CREDIT = 3000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [SLOPE_W-1:0] slope,
    input  logic               keep,
    input  logic [CRED_W-1:0]  limit,
    input  logic               xmit,
    input  logic               pend,
    output logic [CRED_W-1:0]  credit,
    output logic               elig
);

    localparam logic [CRED_W-1:0] STEP       = CRED_W'(SEND_STEP);
    localparam logic [CRED_W-1:0] FLOOR      = CRED_ZERO - CRED_W'(LO_CREDIT);
    localparam logic [CRED_W-1:0] FLOOR_STEP = FLOOR + STEP;
    localparam logic [CRED_W:0]   ZERO_W     = {1'b0, CRED_ZERO};

    typedef struct packed {
        logic [CRED_W-1:0] credit;
    } cred_t;

    cred_t        cr_d, cr_q;
    logic [CRED_W:0] raised;

    assign raised = {1'b0, cr_q.credit} + {{(CRED_W+1-SLOPE_W){1'b0}}, slope};

    always_comb begin
        cr_d = cr_q;
        if (!en) begin
            cr_d.credit = CRED_ZERO;
        end else if (xmit) begin
            cr_d.credit = (cr_q.credit >= FLOOR_STEP) ? cr_q.credit - STEP : FLOOR;
        end else if (pend) begin
            cr_d.credit = (raised > {1'b0, limit}) ? limit : raised[CRED_W-1:0];
        end else if (cr_q.credit > CRED_ZERO) begin
            cr_d.credit = keep ? cr_q.credit : CRED_ZERO;
        end else begin
            cr_d.credit = (raised >= ZERO_W) ? CRED_ZERO : raised[CRED_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cr_q.credit <= CRED_ZERO;
        else        cr_q        <= cr_d;
    end

    assign credit = cr_q.credit;
    assign elig   = !en || (cr_q.credit >= CRED_ZERO);

endmodule

// File: rtl/credit_shaper.sv
module credit_shaper
    import shaper_pkg::*;
#(
    parameter int          NUM_Q       = 4,
    parameter int          NUM_SHAPERS = 2,
    parameter int unsigned SEND_STEP   = 1000,
    parameter int unsigned LO_CREDIT   = 3000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [1:0]               cfg_reg,
    input  logic [$clog2(NUM_Q)-1:0] cfg_queue,
    input  logic [31:0]              cfg_wdata,
    input  logic [NUM_Q-1:0]         q_pend,
    input  logic [NUM_Q-1:0]         q_xmit,
    output logic [NUM_Q-1:0]         q_elig
);

    logic [NUM_SHAPERS-1:0]              shp_en;
    logic [NUM_SHAPERS-1:0][SLOPE_W-1:0] shp_slope;
    logic [NUM_SHAPERS-1:0]              shp_keep;
    logic [NUM_SHAPERS-1:0][CRED_W-1:0]  shp_limit;
    logic [NUM_SHAPERS-1:0][CRED_W-1:0]  shp_credit;

    shaper_cfg #(
        .NUM_Q       (NUM_Q),
        .NUM_SHAPERS (NUM_SHAPERS)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .reg_sel (cfg_reg),
        .queue   (cfg_queue),
        .wdata   (cfg_wdata),
        .en      (shp_en),
        .slope   (shp_slope),
        .keep    (shp_keep),
        .limit   (shp_limit)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_lane
        if (q < NUM_SHAPERS) begin : g_shaped
            shaper_credit #(
                .SEND_STEP (SEND_STEP),
                .LO_CREDIT (LO_CREDIT)
            ) u_credit (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (shp_en[q]),
                .slope  (shp_slope[q]),
                .keep   (shp_keep[q]),
                .limit  (shp_limit[q]),
                .xmit   (q_xmit[q]),
                .pend   (q_pend[q]),
                .credit (shp_credit[q]),
                .elig   (q_elig[q])
            );
        end else begin : g_plain
            logic unused_lane;
            assign unused_lane = q_pend[q] ^ q_xmit[q];
            assign q_elig[q]   = 1'b1;
        end
    end

endmodule

// File: rtl/shaper_chk.sv
module shaper_chk
    import shaper_pkg::*;
#(
    parameter int          NUM_SHAPERS = 2,
    parameter int unsigned SEND_STEP   = 1000,
    parameter int unsigned LO_CREDIT   = 3000
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_SHAPERS-1:0]           pend,
    input logic [NUM_SHAPERS-1:0]           xmit,
    input logic [NUM_SHAPERS-1:0]           shp_en,
    input logic [NUM_SHAPERS-1:0]           shp_keep,
    input logic [NUM_SHAPERS-1:0][CRED_W-1:0] shp_limit,
    input logic [NUM_SHAPERS-1:0][CRED_W-1:0] shp_credit
);

    localparam logic [CRED_W-1:0] FLOOR = CRED_ZERO - CRED_W'(LO_CREDIT);

    a_r10_order: assert property (@(posedge clk) disable iff (!rst_n)
        shp_en[1] |-> shp_en[0]);

    for (genvar i = 0; i < NUM_SHAPERS; i++) begin : g_chk
        a_r11_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !shp_en[i] |=> shp_credit[i] == CRED_ZERO);

        a_r4_cap: assert property (@(posedge clk) disable iff (!rst_n)
            (shp_en[i] && pend[i] && !xmit[i] && shp_credit[i] <= shp_limit[i]
             && shp_limit[i] >= CRED_ZERO)
            |=> shp_credit[i] <= $past(shp_limit[i]));

        a_r7_floor: assert property (@(posedge clk) disable iff (!rst_n)
            (shp_en[i] && xmit[i]) |=> shp_credit[i] >= FLOOR);

        a_r7_fall: assert property (@(posedge clk) disable iff (!rst_n)
            (shp_en[i] && xmit[i] && shp_credit[i] > FLOOR && shp_credit[i] > CRED_ZERO - 32'd1)
            |=> shp_credit[i] < $past(shp_credit[i]));

        a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
            (shp_en[i] && !shp_keep[i] && !pend[i] && !xmit[i] && shp_credit[i] > CRED_ZERO)
            |=> shp_credit[i] == CRED_ZERO);

        a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (shp_en[i] && $past(shp_en[i]) && $past(shp_keep[i]) && !$past(pend[i])
             && !$past(xmit[i]) && $past(shp_credit[i]) >= CRED_ZERO)
            |-> shp_credit[i] == $past(shp_credit[i]));
    end

endmodule

bind credit_shaper shaper_chk #(
    .NUM_SHAPERS (NUM_SHAPERS),
    .SEND_STEP   (SEND_STEP),
    .LO_CREDIT   (LO_CREDIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (q_pend[NUM_SHAPERS-1:0]),
    .xmit       (q_xmit[NUM_SHAPERS-1:0]),
    .shp_en     (shp_en),
    .shp_keep   (shp_keep),
    .shp_limit  (shp_limit),
    .shp_credit (shp_credit)
);

// File: tb/sim_credit_shaper.sv
`timescale 1ns/1ps
module sim_credit_shaper;

    localparam int          SEND = 1000;
    localparam int          LOC  = 3000;
    localparam logic [31:0] ZERO = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_reg = 2'd3;
    logic [1:0]  cfg_queue = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  q_pend = '0;
    logic [3:0]  q_xmit = '0;
    logic [3:0]  q_elig;

    credit_shaper u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_reg(cfg_reg),
        .cfg_queue(cfg_queue), .cfg_wdata(cfg_wdata),
        .q_pend(q_pend), .q_xmit(q_xmit), .q_elig(q_elig)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state, credits relative to the zero point
    int m_c[2];
    bit m_en[2];
    int m_s[2];
    bit m_k[2];
    int m_hi[2];

    // table: {xmit[1:0], pend[1:0], cycles[7:0], expected elig[1:0]}
    localparam logic [13:0] VECS [12] = '{
        {2'b00, 2'b11, 8'd5,  2'b11},
        {2'b11, 2'b00, 8'd1,  2'b00},
        {2'b11, 2'b00, 8'd2,  2'b00},
        {2'b11, 2'b00, 8'd1,  2'b00},
        {2'b00, 2'b00, 8'd20, 2'b00},
        {2'b00, 2'b00, 8'd10, 2'b01},
        {2'b00, 2'b11, 8'd40, 2'b11},
        {2'b00, 2'b00, 8'd1,  2'b11},
        {2'b10, 2'b00, 8'd1,  2'b01},
        {2'b01, 2'b10, 8'd1,  2'b00},
        {2'b00, 2'b10, 8'd9,  2'b10},
        {2'b00, 2'b00, 8'd1,  2'b11}
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: q_elig=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic m_step();
        for (int i = 0; i < 2; i++) begin
            if (!m_en[i])          m_c[i] = 0;
            else if (q_xmit[i])    m_c[i] = (m_c[i] - SEND < -LOC) ? -LOC : m_c[i] - SEND;
            else if (q_pend[i])    m_c[i] = (m_c[i] + m_s[i] > m_hi[i]) ? m_hi[i] : m_c[i] + m_s[i];
            else if (m_c[i] > 0)   m_c[i] = m_k[i] ? m_c[i] : 0;
            else                   m_c[i] = (m_c[i] + m_s[i] > 0) ? 0 : m_c[i] + m_s[i];
        end
    endtask

    task automatic m_cfg();
        int q;
        q = int'(cfg_queue);
        if (q > 1) return;
        case (cfg_reg)
            2'd0: begin
                if (cfg_wdata[7:6] == 2'b00) begin
                    if (q == 1 || !m_en[1]) m_en[q] = 0;
                end else if (cfg_wdata[7:6] == {1'b1, q[0]}) begin
                    if (q == 0 || m_en[0]) m_en[q] = 1;
                end
            end
            2'd1: begin m_s[q] = int'(cfg_wdata[15:0]); m_k[q] = cfg_wdata[30]; end
            2'd2: m_hi[q] = int'($signed(cfg_wdata - ZERO));
            default: ;
        endcase
    endtask

    function automatic logic [1:0] m_elig();
        return {(!m_en[1] || m_c[1] >= 0), (!m_en[0] || m_c[0] >= 0)};
    endfunction

    // one clock: model follows the edge, outputs are compared at the falling edge (R5)
    task automatic tick();
        @(posedge clk);
        m_step();
        if (cfg_wr) m_cfg();
        @(negedge clk);
        check("R5 per-cycle", q_elig, {2'b11, m_elig()});
    endtask

    task automatic run(input logic [3:0] x, input logic [3:0] p, input int n);
        q_xmit = x; q_pend = p;
        for (int k = 0; k < n; k++) tick();
        q_xmit = '0; q_pend = '0;
    endtask

    task automatic wr(input logic [1:0] r, input logic [1:0] q, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_reg = r; cfg_queue = q; cfg_wdata = d;
        tick();
        cfg_wr = 1'b0; cfg_reg = 2'd3;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: expired, actual running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_c[i] = 0; m_en[i] = 0; m_s[i] = 0; m_k[i] = 0; m_hi[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", q_elig, 4'hF);
        run(4'b0001, 4'b0000, 1);
        check("R1 unshaped transmit", q_elig, 4'hF);

        // queue 1 before queue 0: dropped
        wr(2'd0, 2'd1, 32'h0000_00C0);
        run(4'b0010, 4'b0000, 1);
        check("R10 q1 enable ignored", q_elig, 4'hF);

        // bad selects
        wr(2'd0, 2'd2, 32'h0000_0080);
        wr(2'd0, 2'd3, 32'h0000_00C0);
        wr(2'd0, 2'd0, 32'h0000_00C0);
        wr(2'd0, 2'd0, 32'h0000_0040);
        run(4'b1101, 4'b0000, 1);
        check("R2 invalid selects ignored", q_elig, 4'hF);

        // program both shapers (R3, R4)
        wr(2'd1, 2'd0, 32'd100);
        wr(2'd1, 2'd1, 32'd50 | (32'd1 << 30));
        wr(2'd2, 2'd0, ZERO + 32'd250);
        wr(2'd2, 2'd1, ZERO + 32'd1000);
        wr(2'd0, 2'd0, 32'h0000_0080);
        wr(2'd0, 2'd1, 32'h0000_00C0);
        check("R2 enabled eligible at zero", q_elig, 4'hF);
        run(4'b0011, 4'b0000, 1);
        check("R2 R7 shaped after one send", q_elig, 4'b1100);
        run(4'b0000, 4'b0000, 20);
        check("R9 recovered", q_elig, 4'hF);

        // vector table (R6 R7 R8 R9 R3)
        for (int v = 0; v < 12; v++) begin
            run({2'b00, VECS[v][13:12]}, {2'b00, VECS[v][11:10]}, int'(VECS[v][9:2]));
            check($sformatf("R6 R7 R8 R9 R3 row %0d", v), q_elig, {2'b11, VECS[v][1:0]});
        end

        // upper limit clipping
        run(4'b0000, 4'b0001, 5);
        run(4'b0001, 4'b0000, 1);
        run(4'b0000, 4'b0001, 7);
        check("R4 limit clip", q_elig, 4'b1110);
        run(4'b0000, 4'b0001, 1);
        check("R4 limit clip recover", q_elig, 4'hF);
        run(4'b0000, 4'b0000, 1);

        // disabling queue 0 under queue 1: dropped
        wr(2'd0, 2'd0, 32'h0000_0000);
        run(4'b0001, 4'b0000, 1);
        check("R10 q0 disable ignored", q_elig, 4'b1110);

        // proper disable order, then re-enable from zero
        wr(2'd0, 2'd1, 32'h0000_0000);
        wr(2'd0, 2'd0, 32'h0000_0000);
        check("R11 disabled eligible", q_elig, 4'hF);
        wr(2'd0, 2'd0, 32'h0000_0080);
        check("R11 restart at zero", q_elig, 4'hF);
        run(4'b0001, 4'b0000, 1);
        check("R11 shaped again", q_elig, 4'b1110);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule